// File: doc/BRIEF.md
# Bidirectional I/O Port with Drive Override

This block is a group of general-purpose pin ports, each eight bits wide by default. Software reaches two registers per port over a simple read/write interface: a latch that holds the value to drive, and a direction register in which a 1 makes the bit an output and a 0 makes it an input. Toward the pads each bit has three signals: the sampled pin level, the value to drive, and a drive enable.

A single external request pin, `hiz_req_i`, can take selected ports off the wires. When it is high, every output bit of a port that the `GATE_MASK` parameter marks loses its drive enable. Bits configured as inputs, and ports not marked in the mask, do not see it. The pin and all pad inputs pass through a two-flop synchroniser before any logic uses them. The synchronised level of the request pin can be read back from a status register.

Reading a port's data address returns the synchronised pin level for input bits and the latch for output bits. Reads are registered: `rd_data_o` takes its new value at the clock edge that samples `rd_en_i` and holds it until the next read.

Top module: `pio_port`

## Requirements
- R1: After reset, every direction bit and every latch bit is 0, so all drive enables and all drive values are 0 and a direction register reads 0.
- R2: A write to the direction address of port p (address 2p+1) sets that port's direction bits. For a port that is not gated, the drive enable equals the written value from the clock edge of the write onward.
- R3: The drive value of each bit always equals its latch bit, whatever its direction.
- R4: On a port whose `GATE_MASK` bit is 1, all drive enables are 0 starting at the second clock edge after `hiz_req_i` rises. Output bits get their enable back at the second edge after it falls.
- R5: On a port whose `GATE_MASK` bit is 0, `hiz_req_i` has no effect on drive enables or drive values.
- R6: An input bit never has its drive enable set, whether `hiz_req_i` is high or low.
- R7: A read of the data address of port p (address 2p) returns, one edge later, the latch for output bits and the synchronised pin level for input bits.
- R8: A read of the status address (address 2·NPORT) returns the synchronised `hiz_req_i` level in bit 7 and zeros in all other bits.
- R9: A write to the data address updates the latch even while the bit is an input. No drive is enabled then. The stored value is driven once the bit becomes an output.
- R10: A pad input change reaches read data only through two flops: reads captured at the first and second edges after the change return the old level, and the read at the third edge returns the new level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Register address: 2p data, 2p+1 direction, 2·NPORT status |
| wr_data_i | input | WIDTH | Write data |
| rd_data_o | output | WIDTH | Registered read data |
| hiz_req_i | input | 1 | External request to float gated ports (active high) |
| pad_in_i | input | NPORT·WIDTH | Levels sampled from the pads, port p at bits p·WIDTH upward |
| pad_out_o | output | NPORT·WIDTH | Value to drive on each pad |
| pad_oe_o | output | NPORT·WIDTH | Per-pad drive enable |

## Verification
A register write takes effect at the next edge: drive enables and drive values can be sampled one cycle after the write. A change of `hiz_req_i` reaches the drive enables two edges later. A change on a pad input is visible to a read captured at the third edge. A read result appears one edge after the strobe. The bench drives inputs on falling edges and samples on the falling edge after the cycle where each result is due. It waits three cycles after changing any asynchronous input, and it checks once, on purpose, inside the synchroniser window, so that both a missing flop and an extra one show up.

// File: rtl/pio_pkg.sv
package pio_pkg;

  // Register kinds inside one port's address pair.
  typedef enum logic [0:0] {
    REG_LATCH = 1'b0,
    REG_DIR   = 1'b1
  } pio_reg_e;

  function automatic int latch_addr(input int port);
    return 2 * port + int'(REG_LATCH);
  endfunction

  function automatic int dir_addr(input int port);
    return 2 * port + int'(REG_DIR);
  endfunction

  function automatic int status_addr(input int nport);
    return 2 * nport;
  endfunction

endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;

endmodule

// File: rtl/pio_bank.sv
module pio_bank
  import pio_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 3,
  parameter int INDEX  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic [WIDTH-1:0]  pin_sync,
  output logic [WIDTH-1:0]  latch_q,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  view
);

  logic             latch_en;
  logic             dir_en;
  logic [WIDTH-1:0] latch_d;
  logic [WIDTH-1:0] dir_d;

  // Write decode and next-state values.
  always_comb begin
    latch_en = wr_en && (int'(addr) == latch_addr(INDEX));
    dir_en   = wr_en && (int'(addr) == dir_addr(INDEX));
    latch_d  = latch_en ? wr_data : latch_q;
    dir_d    = dir_en   ? wr_data : dir_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else begin
      latch_q <= latch_d;
      dir_q   <= dir_d;
    end
  end

  // Read view: latch for output bits, pin for input bits.
  assign view = (dir_q & latch_q) | (~dir_q & pin_sync);

endmodule

// File: rtl/pio_port.sv
module pio_port
  import pio_pkg::*;
#(
  parameter int               WIDTH     = 8,
  parameter int               NPORT     = 2,
  parameter int               ADDR_W    = $clog2(2 * NPORT + 1),
  parameter logic [NPORT-1:0] GATE_MASK = 2'b01
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic                   rd_en_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [WIDTH-1:0]       wr_data_i,
  output logic [WIDTH-1:0]       rd_data_o,
  input  logic                   hiz_req_i,
  input  logic [NPORT*WIDTH-1:0] pad_in_i,
  output logic [NPORT*WIDTH-1:0] pad_out_o,
  output logic [NPORT*WIDTH-1:0] pad_oe_o
);

  localparam int PINS     = NPORT * WIDTH;
  localparam int STAT_BIT = WIDTH - 1;
  localparam int STAT_A   = status_addr(NPORT);

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_core_n = rst_pipe_q[1];

  // Synchronised pads and override request.
  logic [PINS-1:0] pin_sync;
  logic            hiz_sync;

  pio_sync #(.WIDTH(PINS)) u_pin_sync (
    .clk   (clk_i),
    .rst_n (rst_core_n),
    .d     (pad_in_i),
    .q     (pin_sync)
  );

  pio_sync #(.WIDTH(1)) u_hiz_sync (
    .clk   (clk_i),
    .rst_n (rst_core_n),
    .d     (hiz_req_i),
    .q     (hiz_sync)
  );

  logic [NPORT-1:0][WIDTH-1:0] latch_all;
  logic [NPORT-1:0][WIDTH-1:0] dir_all;
  logic [NPORT-1:0][WIDTH-1:0] view_all;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    pio_bank #(
      .WIDTH  (WIDTH),
      .ADDR_W (ADDR_W),
      .INDEX  (p)
    ) u_bank (
      .clk      (clk_i),
      .rst_n    (rst_core_n),
      .wr_en    (wr_en_i),
      .addr     (addr_i),
      .wr_data  (wr_data_i),
      .pin_sync (pin_sync[p*WIDTH +: WIDTH]),
      .latch_q  (latch_all[p]),
      .dir_q    (dir_all[p]),
      .view     (view_all[p])
    );

    assign pad_out_o[p*WIDTH +: WIDTH] = latch_all[p];

    if (GATE_MASK[p]) begin : g_gated
      assign pad_oe_o[p*WIDTH +: WIDTH] = dir_all[p] & {WIDTH{~hiz_sync}};
    end else begin : g_free
      assign pad_oe_o[p*WIDTH +: WIDTH] = dir_all[p];
    end
  end

  // Registered read path.
  logic [WIDTH-1:0] rd_d;
  logic [WIDTH-1:0] rd_q;

  always_comb begin
    rd_d = rd_q;
    if (rd_en_i) begin
      rd_d = '0;
      if (int'(addr_i) == STAT_A) begin
        rd_d[STAT_BIT] = hiz_sync;
      end
      for (int p = 0; p < NPORT; p++) begin
        if (int'(addr_i) == latch_addr(p)) begin
          rd_d = view_all[p];
        end else if (int'(addr_i) == dir_addr(p)) begin
          rd_d = dir_all[p];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_core_n) begin
    if (!rst_core_n) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_d;
    end
  end

  assign rd_data_o = rd_q;

endmodule

// File: rtl/pio_port_chk.sv
module pio_port_chk #(
  parameter int               WIDTH     = 8,
  parameter int               NPORT     = 2,
  parameter int               ADDR_W    = 3,
  parameter logic [NPORT-1:0] GATE_MASK = 2'b01
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   wr_en,
  input logic                   rd_en,
  input logic [ADDR_W-1:0]      addr,
  input logic [WIDTH-1:0]       wr_data,
  input logic [WIDTH-1:0]       rd_data,
  input logic                   hiz_req,
  input logic [NPORT*WIDTH-1:0] pad_out,
  input logic [NPORT*WIDTH-1:0] pad_oe
);

  localparam int STAT_A = 2 * NPORT;

  // Edges seen since the core reset was released, saturating.
  logic [2:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= '0;
    end else if (age_q != 3'd7) begin
      age_q <= age_q + 3'd1;
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_chk
    AST_LATCH_DRIVES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && (int'(addr) == 2 * p) |=> pad_out[p*WIDTH +: WIDTH] == $past(wr_data)); // R9

    if (GATE_MASK[p]) begin : g_gated
      AST_HIZ_FLOATS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 3'd3) && $past(hiz_req, 2) |-> pad_oe[p*WIDTH +: WIDTH] == '0); // R4
    end else begin : g_free
      AST_DIR_WRITE_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (int'(addr) == 2 * p + 1) |=> pad_oe[p*WIDTH +: WIDTH] == $past(wr_data)); // R2
    end
  end

  AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (int'(addr) == STAT_A) |=> rd_data[WIDTH-2:0] == '0); // R8

  AST_STATUS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 3'd4) && rd_en && (int'(addr) == STAT_A) |=> rd_data[WIDTH-1] == $past(hiz_req, 3)); // R8

endmodule

bind pio_port pio_port_chk #(
  .WIDTH     (WIDTH),
  .NPORT     (NPORT),
  .ADDR_W    (ADDR_W),
  .GATE_MASK (GATE_MASK)
) u_chk (
  .clk     (clk_i),
  .rst_n   (rst_core_n),
  .wr_en   (wr_en_i),
  .rd_en   (rd_en_i),
  .addr    (addr_i),
  .wr_data (wr_data_i),
  .rd_data (rd_data_o),
  .hiz_req (hiz_req_i),
  .pad_out (pad_out_o),
  .pad_oe  (pad_oe_o)
);

// File: tb/tb_pio_port.sv
module tb_pio_port;

  localparam int W  = 8;
  localparam int NP = 2;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [W-1:0]  wdata = '0;
  logic [W-1:0]  rdata;
  logic          hiz = 1'b0;
  logic [NP*W-1:0] pin = '0;
  logic [NP*W-1:0] pout;
  logic [NP*W-1:0] poe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  pio_port #(.WIDTH(W), .NPORT(NP), .ADDR_W(AW), .GATE_MASK(2'b01)) dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .rd_en_i   (rd_en),
    .addr_i    (addr),
    .wr_data_i (wdata),
    .rd_data_o (rdata),
    .hiz_req_i (hiz),
    .pad_in_i  (pin),
    .pad_out_o (pout),
    .pad_oe_o  (poe)
  );

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: act=%0d cycles exp=completion", cycles);
      finish_run();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  // All tasks start and end on a falling edge.
  task automatic wr(input int a, input logic [W-1:0] d);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [W-1:0] d);
    rd_en = 1'b1; addr = AW'(a);
    @(negedge clk);
    d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [W-1:0] v, d, m, pv;
    idle(2);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk("R1 oe", 32'(poe), 32'h0);
    chk("R1 out", 32'(pout), 32'h0);
    rd(1, v); chk("R1 dir0", 32'(v), 32'h0);
    rd(3, v); chk("R1 dir1", 32'(v), 32'h0);

    // Exhaustive direction sweep on the gated port 0, override off
    for (int k = 0; k < 256; k++) begin
      m  = W'(k);
      d  = W'(k * 37 + 11);
      pv = ~m ^ 8'h3C;
      pin[W-1:0] = pv;
      wr(1, m);
      wr(0, d);
      chk("R2 oe0", 32'(poe[W-1:0]), 32'(m));
      chk("R3 out0", 32'(pout[W-1:0]), 32'(d));
      idle(2);
      rd(0, v); chk("R7 view0", 32'(v), 32'((m & d) | (~m & pv)));
      rd(1, v); chk("R2 dir0 readback", 32'(v), 32'(m));
    end

    // Ungated port 1 patterns
    for (int k = 0; k < 16; k++) begin
      m  = W'(k * 17);
      d  = W'(8'hC3 ^ (k * 5));
      pv = W'(k * 29 + 1);
      pin[2*W-1:W] = pv;
      wr(3, m);
      wr(2, d);
      chk("R2 oe1", 32'(poe[2*W-1:W]), 32'(m));
      chk("R3 out1", 32'(pout[2*W-1:W]), 32'(d));
      idle(2);
      rd(2, v); chk("R7 view1", 32'(v), 32'((m & d) | (~m & pv)));
    end

    // Override: port 0 gated, port 1 free
    wr(1, 8'hF0); wr(0, 8'h5A);
    wr(3, 8'hAA); wr(2, 8'h66);
    pin = {8'h00, 8'h09};
    hiz = 1'b1;
    @(negedge clk);
    chk("R4 before sync", 32'(poe[W-1:0]), 32'hF0);
    @(negedge clk);
    chk("R4 gated off", 32'(poe[W-1:0]), 32'h00);
    chk("R5 free port", 32'(poe[2*W-1:W]), 32'hAA);
    chk("R5 free out", 32'(pout[2*W-1:W]), 32'h66);
    chk("R3 out under hiz", 32'(pout[W-1:0]), 32'h5A);
    idle(1);
    rd(0, v); chk("R6 input read under hiz", 32'(v), 32'h59);
    rd(4, v); chk("R8 status high", 32'(v), 32'h80);
    wr(1, 8'h0F);
    chk("R6 hiz dir change", 32'(poe[W-1:0]), 32'h00);
    hiz = 1'b0;
    idle(2);
    chk("R4 restore", 32'(poe[W-1:0]), 32'h0F);
    chk("R6 inputs undriven", 32'(poe[W-1:0] & ~8'h0F), 32'h0);
    idle(1);
    rd(4, v); chk("R8 status low", 32'(v), 32'h00);

    // R9: latch write while input
    wr(1, 8'h00);
    wr(0, 8'h96);
    chk("R9 no drive", 32'(poe[W-1:0]), 32'h00);
    wr(1, 8'hFF);
    chk("R9 drive after dir", 32'(poe[W-1:0]), 32'hFF);
    chk("R9 value", 32'(pout[W-1:0]), 32'h96);
    rd(0, v); chk("R9 read", 32'(v), 32'h96);

    // R10 synchroniser depth on port 1 inputs
    wr(3, 8'h00);
    pin[2*W-1:W] = 8'h11;
    idle(3);
    pin[2*W-1:W] = 8'hE4;
    rd(2, v); chk("R10 edge1 old", 32'(v), 32'h11);
    rd(2, v); chk("R10 edge2 old", 32'(v), 32'h11);
    rd(2, v); chk("R10 edge3 new", 32'(v), 32'hE4);

    finish_run();
  end

endmodule